// File: doc/BRIEF.md
# Indexed Effective-Address Bus Sequencer

This block drives the bus during the operand phase of an 8-bit processor with a 16-bit address space. It starts when the opcode fetch is complete. From then on, it sets the bus address and the read or write strobe for every cycle until the instruction's memory traffic is finished. Along the way it tells the external program counter when to step or when to load a new value. It also marks the cycle in which the datapath should act on the operand (`exec_o`) and the last cycle of the sequence (`done_o`).

The addressing mode and the access class are captured when `start_i` is accepted. The access class is read, store or read-modify-write. The cycle count follows the real bus pattern:

- Pointer arithmetic in page zero wraps inside page zero.
- Indexed reads pay one extra cycle only when the low-byte sum carries.
- Indexed stores and read-modify-write accesses always pay the extra cycle.
- The indirect jump pointer never carries into its high byte.
- Relative branches cost an extra cycle when taken and another one when the target lies in another page.

The `pc_i` input must follow the program counter that this block steps and loads. Read data must be valid in the same cycle as the address that produced it.

Top module: `ea_sequencer`

## Requirements
- R1: While reset is held, and in the idle cycle that follows reset, `rd_o`, `wr_o`, `pc_inc_o`, `pc_ld_o`, `exec_o` and `done_o` are all low.
- R2: `start_i` is accepted only while idle and latches `mode_i` and `acc_i`. The mode codes are 0 direct zero page, 1 zero page+X, 2 zero page+Y, 3 absolute, 4 absolute+X, 5 absolute+Y, 6 (zp,X), 7 (zp),Y, 8 direct jump, 9 indirect jump, 10 branch. The class codes are 0 read, 1 store, 2 read-modify-write, and 3 is treated as read. The first sequence cycle reads at `pc_i` with `pc_inc_o`. Two-byte modes read their second byte at `pc_i` in the next cycle, with `pc_inc_o` high except for the two jump modes.
- R3: Direct zero page uses the operand at `{0x00, b}`. The indexed zero-page modes first do a dummy read at `{0x00, b}` and then use the operand at `{0x00, (b + index) mod 256}`, with X for mode 1 and Y for mode 2.
- R4: Absolute mode uses the operand at `{b2, b1}`.
- R5: An indexed read in modes 4, 5 and 7 reads `{base_hi, (base_lo + index) mod 256}` in the cycle after the base is known. Without a low-byte carry that cycle is the operand cycle. With a carry it is a dummy read, and the operand is read at the full 16-bit sum in the next cycle.
- R6: An indexed store or read-modify-write access in modes 4, 5 and 7 always does a dummy read at the full 16-bit sum before its operand cycle.
- R7: Mode 6 does a dummy read at `{0x00, b}` and sets p = (b + X) mod 256. It then reads the target low byte at `{0x00, p}` and the high byte at `{0x00, (p + 1) mod 256}`.
- R8: Mode 7 reads the base low byte at `{0x00, b}` and the base high byte at `{0x00, (b + 1) mod 256}`, then adds Y as described in R5 and R6.
- R9: The operand cycle depends on the class. A read asserts `rd_o`, `exec_o` and `done_o`. A store asserts `wr_o`, `exec_o` and `done_o`. A read-modify-write access reads the operand, then writes the same address with `exec_o`, then writes it again with `done_o`.
- R10: A direct jump asserts `pc_ld_o` with `{b2, b1}` and `done_o` on the second-byte cycle. An indirect jump reads `{b2, b1}` and then `{b2, (b1 + 1) mod 256}`, and loads `{second, first}` with `done_o` on the last read.
- R11: A branch pulses `exec_o` on the offset fetch and samples `br_take_i` there. If the branch is not taken, `done_o` is also high in that cycle. If it is taken, the next cycle does a dummy read at, and loads, `{pc_hi, pc_lo + offset}`. When the signed offset crosses a page, one more cycle reads and loads the full target with its high byte corrected. `done_o` is high in the last cycle.
- R12: After `done_o` the block is idle for exactly the next cycle, with no strobes. `start_i`, `mode_i` and `acc_i` have no effect while a sequence is running.
- R13: `rd_o` and `wr_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Opcode fetched; begin a sequence (taken only when idle) |
| mode_i | input | 4 | Addressing-mode code |
| acc_i | input | 2 | Access class code |
| x_i | input | 8 | X index register |
| y_i | input | 8 | Y index register |
| pc_i | input | 16 | Current program counter |
| rdata_i | input | 8 | Read data for the current address |
| br_take_i | input | 1 | Branch condition, sampled on the offset fetch |
| addr_o | output | 16 | Bus address |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| pc_inc_o | output | 1 | Step the program counter at the end of this cycle |
| pc_ld_o | output | 1 | Load `pc_val_o` into the program counter |
| pc_val_o | output | 16 | Program counter load value |
| exec_o | output | 1 | Datapath acts on the operand in this cycle |
| done_o | output | 1 | Last cycle of the sequence |

## Verification
The hardest cases to reach are the ones where byte arithmetic wraps or carries at a page edge:
- a zero-page pointer at 0xFF;
- an indirect-jump pointer whose low byte is 0xFF;
- an indexed read whose low sum just carries;
- a branch offset that leaves the page in either direction.

The bench serves memory from an address-hash function with a few overridable locations. Those overrides place chosen pointer and offset bytes at the program counter, so every edge value can be forced directly. Offsets are swept over all 256 values, and indexed modes use random X, Y and program counter values across all three classes.

// File: rtl/ea_seq_pkg.sv
package ea_seq_pkg;
  localparam int DW = 8;
  localparam int AW = 2 * DW;
  localparam int MW = 4;
  localparam int CW = 2;

  typedef enum logic [MW-1:0] {
    M_ZP   = 4'd0,
    M_ZPX  = 4'd1,
    M_ZPY  = 4'd2,
    M_ABS  = 4'd3,
    M_ABSX = 4'd4,
    M_ABSY = 4'd5,
    M_INDX = 4'd6,
    M_INDY = 4'd7,
    M_JMPA = 4'd8,
    M_JMPI = 4'd9,
    M_REL  = 4'd10
  } mode_e;

  typedef enum logic [CW-1:0] {
    ACC_RD  = 2'd0,
    ACC_ST  = 2'd1,
    ACC_RMW = 2'd2
  } acc_e;

  typedef enum logic [3:0] {
    S_IDLE, S_B1, S_B2, S_ZDUM, S_PLO, S_PHI, S_IDXA,
    S_OPR, S_WB1, S_WB2, S_JLO, S_JHI, S_BLO, S_BHI
  } step_e;

  // byte add that stays in its page
  function automatic logic [DW-1:0] wrap_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a + b;
  endfunction

  // low-byte sum with carry out
  function automatic logic [DW:0] carry_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  // signed offset moves the low byte out of its page
  function automatic logic leaves_page(input logic [DW-1:0] lo, input logic [DW-1:0] off);
    logic [DW:0] s;
    s = carry_add(lo, off);
    return off[DW-1] ? ~s[DW] : s[DW];
  endfunction

  function automatic logic [AW-1:0] join_bytes(input logic [DW-1:0] hi, input logic [DW-1:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/ea_seq_calc.sv
module ea_seq_calc
  import ea_seq_pkg::*;
(
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hi_i,
  input  logic [DW-1:0] idx_i,
  input  logic [DW-1:0] pcl_i,
  output logic [AW-1:0] part_o,
  output logic [AW-1:0] full_o,
  output logic          carry_o,
  output logic [DW-1:0] br_lo_o,
  output logic          br_cross_o,
  output logic          br_up_o
);
  logic [DW:0] lsum;

  always_comb begin
    lsum       = carry_add(lo_i, idx_i);
    carry_o    = lsum[DW];
    part_o     = join_bytes(hi_i, lsum[DW-1:0]);
    full_o     = join_bytes(hi_i, lo_i) + {{DW{1'b0}}, idx_i};
    br_lo_o    = wrap_add(pcl_i, lo_i);
    br_cross_o = leaves_page(pcl_i, lo_i);
    br_up_o    = ~lo_i[DW-1];
  end
endmodule

// File: rtl/ea_seq_fsm.sv
module ea_seq_fsm
  import ea_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [MW-1:0] mode_i,
  input  logic [CW-1:0] acc_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          br_take_i,
  input  logic [DW-1:0] idx_i,
  input  logic [AW-1:0] full_i,
  input  logic          carry_i,
  input  logic          br_cross_i,
  input  logic          br_up_i,
  output step_e         step_o,
  output mode_e         mode_o,
  output acc_e          acc_o,
  output logic [DW-1:0] lo_o,
  output logic [DW-1:0] hi_o,
  output logic [DW-1:0] ptr_o,
  output logic [AW-1:0] ea_o,
  output logic          up_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_o <= S_IDLE;
      mode_o <= M_ZP;
      acc_o  <= ACC_RD;
      lo_o   <= '0;
      hi_o   <= '0;
      ptr_o  <= '0;
      ea_o   <= '0;
      up_o   <= 1'b0;
    end else begin
      case (step_o)
        S_IDLE: if (start_i) begin
          mode_o <= mode_e'(mode_i);
          acc_o  <= (acc_i == 2'd3) ? ACC_RD : acc_e'(acc_i);
          step_o <= S_B1;
        end
        S_B1: begin
          lo_o <= rdata_i;
          case (mode_o)
            M_ZPX, M_ZPY, M_INDX: step_o <= S_ZDUM;
            M_ABS, M_ABSX, M_ABSY, M_JMPA, M_JMPI: step_o <= S_B2;
            M_INDY: begin ptr_o <= rdata_i; step_o <= S_PLO; end
            M_REL: step_o <= br_take_i ? S_BLO : S_IDLE;
            default: begin ea_o <= join_bytes('0, rdata_i); step_o <= S_OPR; end
          endcase
        end
        S_B2: begin
          hi_o <= rdata_i;
          case (mode_o)
            M_ABSX, M_ABSY: step_o <= S_IDXA;
            M_JMPA: step_o <= S_IDLE;
            M_JMPI: step_o <= S_JLO;
            default: begin ea_o <= join_bytes(rdata_i, lo_o); step_o <= S_OPR; end
          endcase
        end
        S_ZDUM: begin
          if (mode_o == M_INDX) begin
            ptr_o  <= wrap_add(lo_o, idx_i);
            step_o <= S_PLO;
          end else begin
            ea_o   <= join_bytes('0, wrap_add(lo_o, idx_i));
            step_o <= S_OPR;
          end
        end
        S_PLO: begin lo_o <= rdata_i; step_o <= S_PHI; end
        S_PHI: begin
          hi_o <= rdata_i;
          if (mode_o == M_INDX) begin
            ea_o   <= join_bytes(rdata_i, lo_o);
            step_o <= S_OPR;
          end else begin
            step_o <= S_IDXA;
          end
        end
        S_IDXA: begin
          ea_o   <= full_i;
          step_o <= (acc_o == ACC_RD && !carry_i) ? S_IDLE : S_OPR;
        end
        S_OPR: step_o <= (acc_o == ACC_RMW) ? S_WB1 : S_IDLE;
        S_WB1: step_o <= S_WB2;
        S_WB2: step_o <= S_IDLE;
        S_JLO: begin ptr_o <= rdata_i; step_o <= S_JHI; end
        S_JHI: step_o <= S_IDLE;
        S_BLO: begin
          up_o   <= br_up_i;
          step_o <= br_cross_i ? S_BHI : S_IDLE;
        end
        S_BHI: step_o <= S_IDLE;
        default: step_o <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ea_seq_bus.sv
module ea_seq_bus
  import ea_seq_pkg::*;
(
  input  step_e         step_i,
  input  mode_e         mode_i,
  input  acc_e          acc_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hi_i,
  input  logic [DW-1:0] ptr_i,
  input  logic [AW-1:0] ea_i,
  input  logic [AW-1:0] part_i,
  input  logic [AW-1:0] full_i,
  input  logic          carry_i,
  input  logic [DW-1:0] br_lo_i,
  input  logic          br_cross_i,
  input  logic          up_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          br_take_i,
  output logic [AW-1:0] addr_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic          pc_inc_o,
  output logic          pc_ld_o,
  output logic [AW-1:0] pc_val_o,
  output logic          exec_o,
  output logic          done_o
);
  logic [DW-1:0] pch, pcl;
  logic          rd_final;

  always_comb begin
    pch      = pc_i[AW-1:DW];
    pcl      = pc_i[DW-1:0];
    rd_final = (acc_i == ACC_RD) && !carry_i;
    addr_o   = '0;
    rd_o     = 1'b0;
    wr_o     = 1'b0;
    pc_inc_o = 1'b0;
    pc_ld_o  = 1'b0;
    pc_val_o = '0;
    exec_o   = 1'b0;
    done_o   = 1'b0;
    case (step_i)
      S_B1: begin
        addr_o = pc_i; rd_o = 1'b1; pc_inc_o = 1'b1;
        exec_o = (mode_i == M_REL);
        done_o = (mode_i == M_REL) && !br_take_i;
      end
      S_B2: begin
        addr_o = pc_i; rd_o = 1'b1;
        pc_inc_o = !(mode_i == M_JMPA || mode_i == M_JMPI);
        if (mode_i == M_JMPA) begin
          pc_ld_o = 1'b1; pc_val_o = join_bytes(rdata_i, lo_i); done_o = 1'b1;
        end
      end
      S_ZDUM: begin addr_o = join_bytes('0, lo_i); rd_o = 1'b1; end
      S_PLO:  begin addr_o = join_bytes('0, ptr_i); rd_o = 1'b1; end
      S_PHI:  begin addr_o = join_bytes('0, wrap_add(ptr_i, 8'd1)); rd_o = 1'b1; end
      S_IDXA: begin
        addr_o = (acc_i == ACC_RD) ? part_i : full_i;
        rd_o   = 1'b1;
        exec_o = rd_final;
        done_o = rd_final;
      end
      S_OPR: begin
        addr_o = ea_i;
        rd_o   = (acc_i != ACC_ST);
        wr_o   = (acc_i == ACC_ST);
        exec_o = (acc_i != ACC_RMW);
        done_o = (acc_i != ACC_RMW);
      end
      S_WB1: begin addr_o = ea_i; wr_o = 1'b1; exec_o = 1'b1; end
      S_WB2: begin addr_o = ea_i; wr_o = 1'b1; done_o = 1'b1; end
      S_JLO: begin addr_o = join_bytes(hi_i, lo_i); rd_o = 1'b1; end
      S_JHI: begin
        addr_o   = join_bytes(hi_i, wrap_add(lo_i, 8'd1));
        rd_o     = 1'b1;
        pc_ld_o  = 1'b1;
        pc_val_o = join_bytes(rdata_i, ptr_i);
        done_o   = 1'b1;
      end
      S_BLO: begin
        addr_o   = join_bytes(pch, br_lo_i);
        rd_o     = 1'b1;
        pc_ld_o  = 1'b1;
        pc_val_o = addr_o;
        done_o   = !br_cross_i;
      end
      S_BHI: begin
        addr_o   = join_bytes(pch + (up_i ? 8'd1 : 8'hFF), pcl);
        rd_o     = 1'b1;
        pc_ld_o  = 1'b1;
        pc_val_o = addr_o;
        done_o   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ea_sequencer.sv
module ea_sequencer
  import ea_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [3:0]    mode_i,
  input  logic [1:0]    acc_i,
  input  logic [7:0]    x_i,
  input  logic [7:0]    y_i,
  input  logic [15:0]   pc_i,
  input  logic [7:0]    rdata_i,
  input  logic          br_take_i,
  output logic [15:0]   addr_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic          pc_inc_o,
  output logic          pc_ld_o,
  output logic [15:0]   pc_val_o,
  output logic          exec_o,
  output logic          done_o
);
  step_e         step_q;
  mode_e         mode_q;
  acc_e          acc_q;
  logic [DW-1:0] lo_q, hi_q, ptr_q, idx;
  logic [AW-1:0] ea_q, part, full;
  logic          carry, br_cross, br_up, up_q;
  logic [DW-1:0] br_lo;

  // events brought out for the checker
  logic seq_idle, zp_phase, ix_fix, br_fix;

  assign idx = (mode_q == M_ZPY || mode_q == M_ABSY || mode_q == M_INDY) ? y_i : x_i;

  ea_seq_calc u_calc (
    .lo_i(lo_q), .hi_i(hi_q), .idx_i(idx), .pcl_i(pc_i[DW-1:0]),
    .part_o(part), .full_o(full), .carry_o(carry),
    .br_lo_o(br_lo), .br_cross_o(br_cross), .br_up_o(br_up)
  );

  ea_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .acc_i(acc_i),
    .rdata_i(rdata_i), .br_take_i(br_take_i), .idx_i(idx), .full_i(full),
    .carry_i(carry), .br_cross_i(br_cross), .br_up_i(br_up),
    .step_o(step_q), .mode_o(mode_q), .acc_o(acc_q), .lo_o(lo_q), .hi_o(hi_q),
    .ptr_o(ptr_q), .ea_o(ea_q), .up_o(up_q)
  );

  ea_seq_bus u_bus (
    .step_i(step_q), .mode_i(mode_q), .acc_i(acc_q), .pc_i(pc_i),
    .lo_i(lo_q), .hi_i(hi_q), .ptr_i(ptr_q), .ea_i(ea_q),
    .part_i(part), .full_i(full), .carry_i(carry),
    .br_lo_i(br_lo), .br_cross_i(br_cross), .up_i(up_q),
    .rdata_i(rdata_i), .br_take_i(br_take_i),
    .addr_o(addr_o), .rd_o(rd_o), .wr_o(wr_o), .pc_inc_o(pc_inc_o),
    .pc_ld_o(pc_ld_o), .pc_val_o(pc_val_o), .exec_o(exec_o), .done_o(done_o)
  );

  assign seq_idle = (step_q == S_IDLE);
  assign zp_phase = (step_q == S_ZDUM) || (step_q == S_PLO) || (step_q == S_PHI);
  assign ix_fix   = (step_q == S_IDXA) && (acc_q == ACC_RD) && carry;
  assign br_fix   = (step_q == S_BLO) && br_cross;
endmodule

// File: rtl/ea_seq_chk.sv
module ea_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr_o,
  input logic        rd_o,
  input logic        wr_o,
  input logic        pc_ld_o,
  input logic        done_o,
  input logic        seq_idle,
  input logic        zp_phase,
  input logic        ix_fix,
  input logic        br_fix
);
  // R13
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(rd_o && wr_o));

  // R12
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (seq_idle && !rd_o && !wr_o));

  // R9
  rmw_second_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_o && !done_o) |=> (wr_o && done_o && $stable(addr_o)));

  // R3
  zp_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zp_phase |-> (addr_o[15:8] == 8'h00));

  // R5
  ix_carry_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ix_fix |=> (rd_o && addr_o[15:8] == $past(addr_o[15:8]) + 8'd1
                && addr_o[7:0] == $past(addr_o[7:0])));

  // R11
  br_page_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_fix |=> (pc_ld_o && done_o && addr_o[7:0] == $past(addr_o[7:0])));

  // R10
  load_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_ld_o |-> rd_o);
endmodule

bind ea_sequencer ea_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr_o(addr_o), .rd_o(rd_o), .wr_o(wr_o),
  .pc_ld_o(pc_ld_o), .done_o(done_o), .seq_idle(seq_idle),
  .zp_phase(zp_phase), .ix_fix(ix_fix), .br_fix(br_fix)
);

// File: tb/ea_sequencer_tb.sv
`timescale 1ns/1ps
module ea_sequencer_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, start, br_take;
  logic [3:0] mode;
  logic [1:0] acc;
  logic [7:0] x, y, rdata;
  logic [15:0] pc, addr, pc_val;
  logic rd, wr, pc_inc, pc_ld, exec, done;
  logic pc_set;
  logic [15:0] pc_set_val;

  int checks = 0, failures = 0;

  ea_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .acc_i(acc),
    .x_i(x), .y_i(y), .pc_i(pc), .rdata_i(rdata), .br_take_i(br_take),
    .addr_o(addr), .rd_o(rd), .wr_o(wr), .pc_inc_o(pc_inc), .pc_ld_o(pc_ld),
    .pc_val_o(pc_val), .exec_o(exec), .done_o(done)
  );

  // program counter owned by the bench
  always @(posedge clk) begin
    if (pc_set) pc <= pc_set_val;
    else if (pc_ld) pc <= pc_val;
    else if (pc_inc) pc <= pc + 16'd1;
  end

  // memory: hash of address with a few overridable bytes
  logic [15:0] ov_a [4];
  logic [7:0]  ov_d [4];
  logic        ov_v [4];

  function automatic logic [7:0] mem(input logic [15:0] a);
    logic [7:0] v;
    v = a[7:0] * 8'd37 + a[15:8] * 8'd11 + 8'h5B;
    for (int i = 0; i < 4; i++) if (ov_v[i] && ov_a[i] == a) v = ov_d[i];
    return v;
  endfunction

  always_comb rdata = mem(addr);

  // expected cycle list: {rd,wr,inc,ld,exec,done}
  logic [15:0] e_addr [16];
  logic [5:0]  e_fl   [16];
  logic [15:0] e_val  [16];
  int ne;

  task automatic push(input logic [15:0] a, input logic [5:0] fl, input logic [15:0] v);
    e_addr[ne] = a; e_fl[ne] = fl; e_val[ne] = v; ne++;
  endtask

  task automatic opr(input logic [1:0] c, input logic [15:0] ea);
    if (c == 2'd1) push(ea, 6'b010011, 0);
    else if (c == 2'd2) begin
      push(ea, 6'b100000, 0); push(ea, 6'b010010, 0); push(ea, 6'b010001, 0);
    end else push(ea, 6'b100011, 0);
  endtask

  task automatic indexed(input logic [1:0] c, input logic [7:0] bl, input logic [7:0] bh,
                         input logic [7:0] ix);
    logic [15:0] full, part;
    full = {bh, bl} + {8'h00, ix};
    part = {bh, bl + ix};
    if (c == 2'd0 || c == 2'd3) begin
      if (part == full) push(part, 6'b100011, 0);
      else begin push(part, 6'b100000, 0); opr(c, full); end
    end else begin
      push(full, 6'b100000, 0); opr(c, full);
    end
  endtask

  task automatic build(input int m, input logic [1:0] c, input logic [7:0] xx,
                       input logic [7:0] yy, input logic [15:0] p, input logic tk);
    logic [7:0] b1, b2, lo, hi, q;
    logic [15:0] np, t;
    ne = 0;
    b1 = mem(p);
    b2 = mem(p + 16'd1);
    case (m)
      0: begin push(p, 6'b101000, 0); opr(c, {8'h00, b1}); end
      1, 2: begin
        push(p, 6'b101000, 0); push({8'h00, b1}, 6'b100000, 0);
        opr(c, {8'h00, b1 + ((m == 1) ? xx : yy)});
      end
      3: begin push(p, 6'b101000, 0); push(p + 16'd1, 6'b101000, 0); opr(c, {b2, b1}); end
      4, 5: begin
        push(p, 6'b101000, 0); push(p + 16'd1, 6'b101000, 0);
        indexed(c, b1, b2, (m == 4) ? xx : yy);
      end
      6: begin
        push(p, 6'b101000, 0); push({8'h00, b1}, 6'b100000, 0);
        q = b1 + xx;
        lo = mem({8'h00, q}); push({8'h00, q}, 6'b100000, 0);
        q = q + 8'd1;
        hi = mem({8'h00, q}); push({8'h00, q}, 6'b100000, 0);
        opr(c, {hi, lo});
      end
      7: begin
        push(p, 6'b101000, 0);
        lo = mem({8'h00, b1}); push({8'h00, b1}, 6'b100000, 0);
        q = b1 + 8'd1;
        hi = mem({8'h00, q}); push({8'h00, q}, 6'b100000, 0);
        indexed(c, lo, hi, yy);
      end
      8: begin push(p, 6'b101000, 0); push(p + 16'd1, 6'b100101, {b2, b1}); end
      9: begin
        push(p, 6'b101000, 0); push(p + 16'd1, 6'b100000, 0);
        lo = mem({b2, b1}); push({b2, b1}, 6'b100000, 0);
        hi = mem({b2, b1 + 8'd1}); push({b2, b1 + 8'd1}, 6'b100101, {hi, lo});
      end
      default: begin
        push(p, tk ? 6'b101010 : 6'b101011, 0);
        if (tk) begin
          np = p + 16'd1;
          t = np + {{8{b1[7]}}, b1};
          if (t[15:8] == np[15:8]) push(t, 6'b100101, t);
          else begin
            push({np[15:8], t[7:0]}, 6'b100100, {np[15:8], t[7:0]});
            push(t, 6'b100101, t);
          end
        end
      end
    endcase
  endtask

  task automatic run(input int m, input logic [1:0] c, input logic [7:0] xx,
                     input logic [7:0] yy, input logic [15:0] p, input logic tk,
                     input logic hold, input string tag);
    logic [15:0] ga, gv;
    logic [5:0]  gf;
    logic bad, rwbad;
    build(m, c, xx, yy, p, tk);
    bad = 1'b0; rwbad = 1'b0;
    @(negedge clk);
    x = xx; y = yy; br_take = tk;
    mode = 4'(m); acc = c; start = 1'b1;
    pc_set = 1'b1; pc_set_val = p;
    for (int k = 0; k < ne; k++) begin
      @(negedge clk);
      pc_set = 1'b0;
      ga = addr; gf = {rd, wr, pc_inc, pc_ld, exec, done}; gv = pc_ld ? pc_val : 16'h0;
      if (rd && wr) rwbad = 1'b1;
      if (!bad && (ga !== e_addr[k] || gf !== e_fl[k] || gv !== e_val[k])) begin
        bad = 1'b1;
        $display("FAIL %s mode=%0d acc=%0d cyc=%0d: got addr=%h fl=%b val=%h exp addr=%h fl=%b val=%h",
                 tag, m, c, k, ga, gf, gv, e_addr[k], e_fl[k], e_val[k]);
      end
      // R12: inputs change mid-sequence without effect
      start = hold && (k != ne - 1);
      mode = ~4'(m); acc = ~c;
    end
    checks++; if (bad) failures++;
    checks++;
    if (rwbad) begin
      failures++; $display("FAIL R13 mode=%0d: rd and wr together, exp exclusive", m);
    end
    @(negedge clk);
    checks++;
    if (rd || wr || done || exec || pc_ld || pc_inc) begin
      failures++;
      $display("FAIL R12 idle after done: got rd=%b wr=%b done=%b exp all 0", rd, wr, done);
    end
  endtask

  logic [31:0] rs = 32'h1234_5678;
  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] v;
    v = s ^ (s << 13); v = v ^ (v >> 17); v = v ^ (v << 5);
    return v;
  endfunction

  task automatic clr_ov();
    for (int i = 0; i < 4; i++) ov_v[i] = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired: run did not finish, exp completion");
    checks++; failures++;
    summary();
    $finish;
  end

  initial begin
    string tg;
    clr_ov();
    rst_n = 1'b0; start = 1'b0; mode = 0; acc = 0; x = 0; y = 0; br_take = 0;
    pc_set = 1'b1; pc_set_val = 16'h0;
    repeat (3) @(negedge clk);
    checks++;
    if (rd || wr || pc_inc || pc_ld || exec || done) begin
      failures++; $display("FAIL R1 in reset: got strobes rd=%b wr=%b done=%b exp 0", rd, wr, done);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rd || wr || pc_inc || pc_ld || exec || done) begin
      failures++; $display("FAIL R1 idle after reset: got rd=%b wr=%b exp 0", rd, wr);
    end

    // R2 R3 R4 R5 R6 R7 R8 R9: all data modes and classes, random operands
    for (int m = 0; m <= 7; m++)
      for (int c = 0; c <= 3; c++)
        for (int i = 0; i < 40; i++) begin
          rs = nxt(rs);
          case (m)
            0, 1, 2: tg = "R2/R3/R9";
            3: tg = "R2/R4/R9";
            4, 5: tg = (c == 1 || c == 2) ? "R6/R9" : "R5/R9";
            6: tg = "R7/R9";
            default: tg = "R8/R5/R6";
          endcase
          run(m, 2'(c), rs[7:0], rs[15:8], rs[31:16], 1'b0, i[0], tg);
        end

    // R3 R7: zero-page pointer wrap at 0xFF
    rs = nxt(rs);
    ov_a[0] = rs[31:16]; ov_d[0] = 8'h80; ov_v[0] = 1'b1;
    run(6, 2'd0, 8'h7F, 8'h00, rs[31:16], 1'b0, 1'b0, "R7");
    run(1, 2'd2, 8'h90, 8'h00, rs[31:16], 1'b0, 1'b0, "R3");
    ov_d[0] = 8'hFF;
    run(7, 2'd0, 8'h00, 8'hFF, rs[31:16], 1'b0, 1'b0, "R8");
    run(7, 2'd1, 8'h00, 8'h01, rs[31:16], 1'b0, 1'b0, "R8");
    clr_ov();

    // R10: direct and indirect jumps
    for (int i = 0; i < 64; i++) begin
      rs = nxt(rs);
      run(8, 2'd0, 8'h00, 8'h00, rs[31:16], 1'b0, 1'b0, "R10");
      run(9, 2'd0, 8'h00, 8'h00, rs[15:0], 1'b0, 1'b1, "R10");
    end
    // R10: pointer 0x08FF takes its high byte from 0x0800
    ov_a[0] = 16'h3000; ov_d[0] = 8'hFF; ov_v[0] = 1'b1;
    ov_a[1] = 16'h3001; ov_d[1] = 8'h08; ov_v[1] = 1'b1;
    ov_a[2] = 16'h08FF; ov_d[2] = 8'h34; ov_v[2] = 1'b1;
    ov_a[3] = 16'h0800; ov_d[3] = 8'h12; ov_v[3] = 1'b1;
    run(9, 2'd0, 8'h00, 8'h00, 16'h3000, 1'b0, 1'b0, "R10 pointer wrap");
    @(negedge clk);
    checks++;
    if (pc !== 16'h1234) begin
      failures++; $display("FAIL R10 indirect target: got pc=%h exp 1234", pc);
    end
    clr_ov();

    // R11: every offset, taken and not taken
    for (int o = 0; o < 256; o++)
      for (int tk = 0; tk < 2; tk++) begin
        rs = nxt(rs);
        ov_a[0] = rs[15:0]; ov_d[0] = 8'(o); ov_v[0] = 1'b1;
        run(10, 2'd0, 8'h00, 8'h00, rs[15:0], tk[0], 1'b0, "R11");
      end
    clr_ov();

    summary();
    $finish;
  end
endmodule